// File: doc/BRIEF.md
# I2C Host Status Flag Register

This block holds the eight-bit status word of an I2C host controller. The protocol engine and the bus monitor report completion and fault events as single-cycle pulses. The block latches each one into a sticky flag. Software reads the flags through a plain register-bus port. Each flag is cleared by writing one to its bit, or as a side effect when software touches a neighbouring host register. The neighbouring register decoders report those accesses on dedicated strobe inputs. The bus-error flag responds to fewer of these side effects than the other flags.

The word also carries two fields that are not sticky flags. One is a received-acknowledge bit, which follows the last acknowledge seen from the client. The other is a two-bit bus-state field, which the engine loads and which software can only force to idle. Two interrupt request outputs combine the completion flags with their enable inputs.

Bit layout, MSB to LSB:
- bit 7: read-complete
- bit 6: write-complete
- bit 5: clock-hold
- bit 4: received-ack
- bit 3: arbitration-lost
- bit 2: bus-error
- bits 1:0: bus state

Bus-state encoding: 0 unknown, 1 idle, 2 owner, 3 busy.

Top module: `i2c_host_status`

## Requirements
- R1: After a synchronous reset the status word reads 0x00, and both interrupt requests are low.
- R2: A read-done pulse sets bit 7. A write-done pulse sets bit 6, also when an arbitration-loss or bus-error pulse arrives in the same cycle. A hold pulse sets bit 5, an arbitration-loss pulse sets bit 3 and a bus-error pulse sets bit 2. Each bit is visible on the first read after the clock edge that sampled its pulse.
- R3: A status write with a 1 in bit 7, 6, 5, 3 or 2 clears that flag. A 0 in the same position leaves the flag unchanged.
- R4: A host-address-write strobe clears bits 7, 6, 5, 3 and 2.
- R5: A data-access strobe or a command-write strobe clears bits 7, 6, 5 and 3 and leaves bit 2 unchanged.
- R6: When a set pulse and any clear source for the same flag arrive in one cycle, the flag ends up set.
- R7: Bit 4 takes the value of the nack input on each cycle in which ack-valid is high (1 means NACK, 0 means ACK). Status writes do not change bit 4.
- R8: A state-update pulse loads bits 1:0 from the engine. A status write whose bits 1:0 equal 1 forces the field to 1 (idle). Writes of 0, 2 or 3 in that field leave it unchanged. An engine update in the same cycle as a force takes priority.
- R9: `rd_irq` equals bit 7 AND `rd_irq_en`. `wr_irq` equals bit 6 AND `wr_irq_en`.
- R10: `bus_rdata` shows the status word while `bus_rd` is high with `bus_addr` equal to the status address (default 5), and 0 otherwise. Reading the status word changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register-bus address |
| bus_wr | input | 1 | Register-bus write strobe |
| bus_rd | input | 1 | Register-bus read strobe |
| bus_wdata | input | 8 | Register-bus write data |
| bus_rdata | output | 8 | Register-bus read data |
| ev_rd_done | input | 1 | Host byte read finished |
| ev_wr_done | input | 1 | Address transmit or byte write finished |
| ev_hold | input | 1 | Host started holding SCL low |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Illegal start/stop sequence seen |
| ev_ack_valid | input | 1 | An acknowledge bit was sampled |
| ev_ack_nack | input | 1 | Sampled acknowledge was NACK |
| ev_state_upd | input | 1 | Load a new bus state |
| ev_state | input | 2 | New bus state from the monitor |
| acc_addr_wr | input | 1 | Host address register was written |
| acc_data | input | 1 | Host data register was read or written |
| acc_cmd_wr | input | 1 | Command field was written |
| rd_irq_en | input | 1 | Read interrupt enable |
| wr_irq_en | input | 1 | Write interrupt enable |
| rd_irq | output | 1 | Read interrupt request |
| wr_irq | output | 1 | Write interrupt request |

## Verification
Every flag is a single register that feeds the read port directly. A wrong set or clear decision therefore shows up on the very next status read, one clock after the offending event or access. A wrong clear mapping in the bus-error cell shows up as a missing bit 2 after a data or command access. A wrong bus-state priority shows up as a wrong low field after the cycle that carried both an update and a force. The interrupt outputs are combinational from the flags, so a fault in a completion flag also shows on `rd_irq` or `wr_irq` in the same cycle as on the read data.

// File: rtl/hsts_pkg.sv
package hsts_pkg;

    localparam int STATUS_W = 8;
    localparam int NFLAG    = 5;

    localparam int FI_RD   = 0;
    localparam int FI_WR   = 1;
    localparam int FI_HOLD = 2;
    localparam int FI_ARB  = 3;
    localparam int FI_ERR  = 4;

    localparam int POS_ACK = 4;

    typedef enum logic [1:0] {
        BS_UNKNOWN = 2'd0,
        BS_IDLE    = 2'd1,
        BS_OWNER   = 2'd2,
        BS_BUSY    = 2'd3
    } bus_state_e;

    // Status bit position of each sticky flag index.
    function automatic int flag_pos(input int idx);
        case (idx)
            FI_RD:   return 7;
            FI_WR:   return 6;
            FI_HOLD: return 5;
            FI_ARB:  return 3;
            default: return 2;
        endcase
    endfunction

    // Whether data and command accesses clear this flag.
    function automatic bit wide_clear(input int idx);
        return idx != FI_ERR;
    endfunction

endpackage

// File: rtl/hsts_sticky_flag.sv
module hsts_sticky_flag #(
    parameter bit WIDE_CLR = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic w1c_i,
    input  logic addr_clr_i,
    input  logic data_clr_i,
    input  logic cmd_clr_i,
    output logic q
);

    logic clr;

    always_comb begin
        clr = w1c_i | addr_clr_i;
        if (WIDE_CLR) clr = clr | data_clr_i | cmd_clr_i;
    end

    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr)   q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!set_i && w1c_i) |=> !q); // R3
    AST_ADDR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!set_i && addr_clr_i) |=> !q); // R4

    generate
        if (WIDE_CLR) begin : g_wide
            AST_SIDE_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (!set_i && (data_clr_i || cmd_clr_i)) |=> !q); // R5
        end else begin : g_narrow
            AST_ERR_KEEPS: assert property (@(posedge clk) disable iff (rst)
                (!set_i && !w1c_i && !addr_clr_i) |=> $stable(q)); // R5
        end
    endgenerate

endmodule

// File: rtl/hsts_ack_track.sv
module hsts_ack_track (
    input  logic clk,
    input  logic rst,
    input  logic valid_i,
    input  logic nack_i,
    output logic nack_q
);

    always_ff @(posedge clk) begin
        if (rst)          nack_q <= 1'b0;
        else if (valid_i) nack_q <= nack_i;
    end

    AST_ACK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (nack_q == $past(nack_i))); // R7
    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(nack_q)); // R7

endmodule

// File: rtl/hsts_bus_state.sv
module hsts_bus_state
    import hsts_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_i,
    input  bus_state_e upd_state_i,
    input  logic       wr_i,
    input  logic [1:0] wr_field_i,
    output bus_state_e state_q
);

    logic force_idle;
    assign force_idle = wr_i && (wr_field_i == 2'(BS_IDLE));

    always_ff @(posedge clk) begin
        if (rst)             state_q <= BS_UNKNOWN;
        else if (upd_i)      state_q <= upd_state_i;
        else if (force_idle) state_q <= BS_IDLE;
    end

    AST_FORCE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!upd_i && force_idle) |=> (state_q == BS_IDLE)); // R8
    AST_ENGINE_WINS: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> (state_q == $past(upd_state_i))); // R8
    AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!upd_i && !force_idle) |=> $stable(state_q)); // R8

endmodule

// File: rtl/i2c_host_status.sv
module i2c_host_status
    import hsts_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int STATUS_ADDR = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [STATUS_W-1:0] bus_wdata,
    output logic [STATUS_W-1:0] bus_rdata,
    input  logic                ev_rd_done,
    input  logic                ev_wr_done,
    input  logic                ev_hold,
    input  logic                ev_arb_lost,
    input  logic                ev_bus_err,
    input  logic                ev_ack_valid,
    input  logic                ev_ack_nack,
    input  logic                ev_state_upd,
    input  logic [1:0]          ev_state,
    input  logic                acc_addr_wr,
    input  logic                acc_data,
    input  logic                acc_cmd_wr,
    input  logic                rd_irq_en,
    input  logic                wr_irq_en,
    output logic                rd_irq,
    output logic                wr_irq
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STATUS_ADDR);

    logic                hit;
    logic                wr_hit;
    logic [NFLAG-1:0]    set_vec;
    logic [NFLAG-1:0]    flag_q;
    logic                nack_q;
    bus_state_e          state_q;
    logic [STATUS_W-1:0] status;

    assign hit    = (bus_addr == HIT_ADDR);
    assign wr_hit = bus_wr && hit;

    always_comb begin
        set_vec          = '0;
        set_vec[FI_RD]   = ev_rd_done;
        set_vec[FI_WR]   = ev_wr_done;
        set_vec[FI_HOLD] = ev_hold;
        set_vec[FI_ARB]  = ev_arb_lost;
        set_vec[FI_ERR]  = ev_bus_err;
    end

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            hsts_sticky_flag #(
                .WIDE_CLR (wide_clear(i))
            ) u_flag (
                .clk        (clk),
                .rst        (rst),
                .set_i      (set_vec[i]),
                .w1c_i      (wr_hit && bus_wdata[flag_pos(i)]),
                .addr_clr_i (acc_addr_wr),
                .data_clr_i (acc_data),
                .cmd_clr_i  (acc_cmd_wr),
                .q          (flag_q[i])
            );
        end
    endgenerate

    hsts_ack_track u_ack (
        .clk     (clk),
        .rst     (rst),
        .valid_i (ev_ack_valid),
        .nack_i  (ev_ack_nack),
        .nack_q  (nack_q)
    );

    hsts_bus_state u_state (
        .clk         (clk),
        .rst         (rst),
        .upd_i       (ev_state_upd),
        .upd_state_i (bus_state_e'(ev_state)),
        .wr_i        (wr_hit),
        .wr_field_i  (bus_wdata[1:0]),
        .state_q     (state_q)
    );

    always_comb begin
        status          = '0;
        status[1:0]     = state_q;
        status[POS_ACK] = nack_q;
        for (int i = 0; i < NFLAG; i++) begin
            status[flag_pos(i)] = flag_q[i];
        end
    end

    assign bus_rdata = (bus_rd && hit) ? status : '0;
    assign rd_irq    = flag_q[FI_RD] & rd_irq_en;
    assign wr_irq    = flag_q[FI_WR] & wr_irq_en;

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (flag_q == '0 && !nack_q && state_q == BS_UNKNOWN)); // R1
    AST_WR_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_wr_done |=> wr_irq || !wr_irq_en); // R2

endmodule

// File: tb/i2c_host_status_tb.sv
module i2c_host_status_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ev_rd_done = 0, ev_wr_done = 0, ev_hold = 0, ev_arb_lost = 0, ev_bus_err = 0;
    logic       ev_ack_valid = 0, ev_ack_nack = 0, ev_state_upd = 0;
    logic [1:0] ev_state = '0;
    logic       acc_addr_wr = 0, acc_data = 0, acc_cmd_wr = 0;
    logic       rd_irq_en = 0, wr_irq_en = 0;
    logic       rd_irq, wr_irq;

    int total = 0;
    int bad   = 0;

    localparam logic [3:0] ST_ADDR = 4'd5;

    always #5 clk = ~clk;

    i2c_host_status u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rd_done(ev_rd_done), .ev_wr_done(ev_wr_done), .ev_hold(ev_hold),
        .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err),
        .ev_ack_valid(ev_ack_valid), .ev_ack_nack(ev_ack_nack),
        .ev_state_upd(ev_state_upd), .ev_state(ev_state),
        .acc_addr_wr(acc_addr_wr), .acc_data(acc_data), .acc_cmd_wr(acc_cmd_wr),
        .rd_irq_en(rd_irq_en), .wr_irq_en(wr_irq_en), .rd_irq(rd_irq), .wr_irq(wr_irq)
    );

    // Vector: {events[4:0] = rd,wr,hold,arb,err ; action[2:0] ; wdata ; expected}
    // action: 0 none, 1 status write, 2 address strobe, 3 data strobe, 4 command strobe
    localparam int NVEC = 14;
    localparam logic [23:0] VEC [NVEC] = '{
        {5'b11111, 3'd0, 8'h00, 8'hEC},  // R2 all flags set
        {5'b00000, 3'd3, 8'h00, 8'h04},  // R5 data access keeps bus error
        {5'b11111, 3'd4, 8'h00, 8'h04},  // R5 command write keeps bus error
        {5'b00000, 3'd2, 8'h00, 8'h00},  // R4 address write clears all
        {5'b11111, 3'd1, 8'h80, 8'h6C},  // R3 w1c bit 7
        {5'b00000, 3'd1, 8'h40, 8'h2C},  // R3 w1c bit 6
        {5'b00000, 3'd1, 8'h20, 8'h0C},  // R3 w1c bit 5
        {5'b00000, 3'd1, 8'h08, 8'h04},  // R3 w1c bit 3
        {5'b00000, 3'd1, 8'h04, 8'h00},  // R3 w1c bit 2
        {5'b11111, 3'd1, 8'h00, 8'hEC},  // R3 writing zeros changes nothing
        {5'b00000, 3'd1, 8'h13, 8'hEC},  // R7 R8 ack bit and state write 3 ignored
        {5'b00000, 3'd3, 8'h00, 8'h04},  // R5 data access again
        {5'b01000, 3'd0, 8'h00, 8'h44},  // R2 write-complete alone
        {5'b00000, 3'd1, 8'hFF, 8'h00}   // R3 R8 clear all, state write 3 ignored
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_status(output logic [7:0] v);
        bus_addr = ST_ADDR;
        bus_rd   = 1'b1;
        #1 v = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    task automatic set_events(input logic [4:0] e);
        {ev_rd_done, ev_wr_done, ev_hold, ev_arb_lost, ev_bus_err} = e;
    endtask

    task automatic status_write(input logic [7:0] d);
        bus_addr  = ST_ADDR;
        bus_wr    = 1'b1;
        bus_wdata = d;
        tick();
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        tick();
        rst = 1'b0;

        // R1 reset state
        read_status(v);
        check("R1 reset word", v, 8'h00);
        check("R1 irq low", {6'd0, rd_irq, wr_irq}, 8'h00);

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            set_events(VEC[i][23:19]);
            tick();
            set_events(5'b0);
            case (VEC[i][18:16])
                3'd1: status_write(VEC[i][15:8]);
                3'd2: begin acc_addr_wr = 1; tick(); acc_addr_wr = 0; end
                3'd3: begin acc_data = 1; tick(); acc_data = 0; end
                3'd4: begin acc_cmd_wr = 1; tick(); acc_cmd_wr = 0; end
                default: ;
            endcase
            read_status(v);
            check($sformatf("R2-R5 vector %0d", i), v, VEC[i][7:0]);
        end

        // R6 set beats clear in the same cycle
        ev_rd_done = 1; acc_data = 1; tick(); ev_rd_done = 0; acc_data = 0;
        read_status(v);
        check("R6 set wins over data clear", v, 8'h80);
        ev_bus_err = 1; acc_addr_wr = 1; tick(); ev_bus_err = 0; acc_addr_wr = 0;
        read_status(v);
        check("R6 set wins over address clear", v, 8'h04);
        acc_addr_wr = 1; tick(); acc_addr_wr = 0;

        // R2 write-complete with concurrent faults
        ev_wr_done = 1; ev_bus_err = 1; ev_arb_lost = 1; tick();
        ev_wr_done = 0; ev_bus_err = 0; ev_arb_lost = 0;
        read_status(v);
        check("R2 write done with faults", v, 8'h4C);

        // R9 interrupt requests
        check("R9 wr_irq disabled", {7'd0, wr_irq}, 8'h00);
        wr_irq_en = 1; #1;
        check("R9 wr_irq enabled", {7'd0, wr_irq}, 8'h01);
        check("R9 rd_irq no flag", {7'd0, rd_irq}, 8'h00);
        ev_rd_done = 1; tick(); ev_rd_done = 0;
        check("R9 rd_irq flag no enable", {7'd0, rd_irq}, 8'h00);
        rd_irq_en = 1; #1;
        check("R9 rd_irq enabled", {7'd0, rd_irq}, 8'h01);
        acc_cmd_wr = 1; tick(); acc_cmd_wr = 0;
        check("R9 irqs drop after command clear", {6'd0, rd_irq, wr_irq}, 8'h00);
        acc_addr_wr = 1; tick(); acc_addr_wr = 0;

        // R7 received acknowledge
        ev_ack_valid = 1; ev_ack_nack = 1; tick(); ev_ack_valid = 0; ev_ack_nack = 0;
        read_status(v);
        check("R7 nack captured", v, 8'h10);
        ev_ack_nack = 0; tick();
        read_status(v);
        check("R7 holds without valid", v, 8'h10);
        status_write(8'h10);
        read_status(v);
        check("R7 write ignored", v, 8'h10);
        ev_ack_valid = 1; tick(); ev_ack_valid = 0;
        read_status(v);
        check("R7 ack captured", v, 8'h00);

        // R8 bus state
        ev_state_upd = 1; ev_state = 2'd2; tick(); ev_state_upd = 0;
        read_status(v);
        check("R8 engine load owner", v, 8'h02);
        status_write(8'h01);
        read_status(v);
        check("R8 force idle", v, 8'h01);
        ev_state_upd = 1; ev_state = 2'd3; tick(); ev_state_upd = 0;
        status_write(8'h02);
        read_status(v);
        check("R8 write 2 ignored", v, 8'h03);
        status_write(8'h00);
        read_status(v);
        check("R8 write 0 ignored", v, 8'h03);
        ev_state_upd = 1; ev_state = 2'd2;
        status_write(8'h01);
        ev_state_upd = 0;
        read_status(v);
        check("R8 engine beats force", v, 8'h02);

        // R10 read port qualification
        ev_hold = 1; tick(); ev_hold = 0;
        bus_addr = 4'd6; bus_rd = 1; #1;
        check("R10 other address reads zero", bus_rdata, 8'h00);
        bus_addr = ST_ADDR; bus_rd = 0; #1;
        check("R10 no strobe reads zero", bus_rdata, 8'h00);
        tick();
        read_status(v);
        check("R10 status read has no side effect", v, 8'h22);
        bus_addr = 4'd6; bus_wr = 1; bus_wdata = 8'hFF; tick(); bus_wr = 0; bus_wdata = 0;
        read_status(v);
        check("R10 write to other address ignored", v, 8'h22);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule